// File: doc/BRIEF.md
# Complementary Predicate Register File

This block holds the guard predicates of a statically scheduled, multi-slot pipeline that executes predicated code. Each predicate is kept as two bits: one for its true sense and one for its false sense. A single compare sets one bit to the relation result and the other bit to its inverse. A clear drives both bits low, which gives the "neither arm" state that nested conditionals need. Spill and restore operations move one predicate pair at a time between the file and a register held around a call.

Every instruction names a guard: a predicate index and a sense bit. The block evaluates compares in the execute stage. It looks the guard up in the memory stage and registers a writeback enable for the writeback stage. When the guard is false, the instruction is squashed late. Its integer result is dropped through the enable output, and its own predicate write is dropped inside the file. Within one issue bundle, a slot sees the predicate writes of all lower-numbered slots. A compare and an instruction guarded on its result can therefore issue in the same cycle. The next bundle sees every write of the bundle before it. Index 0 is a null predicate whose true sense is always 1 and which cannot be written.

Top module: `cpred_file`

## Requirements
- R1: After reset, every predicate except index 0 holds the both-false pair, so an instruction guarded on either sense of it is squashed.
- R2: A stored predicate pair only ever takes the values false/false, true/false or false/true, as long as a restore never supplies both bits set.
- R3: A clear (op code 1) whose guard passes sets both bits of the destination predicate to 0, so later guards on either sense of it are squashed.
- R4: A compare (op code 2) whose guard passes writes the relation result to the true bit and its inverse to the false bit of the destination. The relation codes are 0 equal, 1 not-equal, 2 greater-than and 3 less-than, comparing operand A with operand B.
- R5: When the unsigned flag of a compare is 1, greater-than and less-than treat the operands as unsigned; when it is 0 they treat them as two's-complement signed.
- R6: The writeback enable of a slot is 1 two clock edges after issue exactly when the slot was valid and the guard bit it selected (true bit when the sense input is 0, false bit when it is 1) was 1. Op codes 0, 5, 6 and 7 write no predicate.
- R7: A clear, compare or restore whose guard is false leaves its destination pair unchanged; this includes a compare guarded by a false predicate when building a nested condition.
- R8: A slot's guard and spill read see the writes of lower-numbered slots in the same bundle, which gives a compare-to-use distance of zero. When two slots in a bundle write one predicate, the higher-numbered slot's write is the one kept.
- R9: A spill (op code 4) presents the destination pair as {true, false} on the spill output two edges after issue, and a restore (op code 3) whose guard passes writes the supplied {true, false} pair.
- R10: Predicate index 0 reads as true/false at all times. A guard on its true sense always passes, a guard on its false sense is always squashed, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | SLOTS | Per-slot instruction valid at issue (execute stage) |
| iss_op | input | SLOTS*3 | Per-slot op: 0 plain, 1 clear, 2 compare, 3 restore, 4 spill |
| iss_rel | input | SLOTS*2 | Per-slot compare relation: 0 eq, 1 ne, 2 gt, 3 lt |
| iss_unsigned | input | SLOTS | Per-slot compare is unsigned when 1 |
| iss_opa | input | SLOTS*DATA_W | Per-slot compare operand A |
| iss_opb | input | SLOTS*DATA_W | Per-slot compare operand B |
| iss_dst | input | SLOTS*IW | Per-slot destination predicate index for clear, compare, restore and spill |
| iss_gidx | input | SLOTS*IW | Per-slot guard predicate index |
| iss_gneg | input | SLOTS | Per-slot guard sense: 0 true bit, 1 false bit |
| iss_rdata | input | SLOTS*2 | Per-slot restore pair {true, false} |
| wb_en | output | SLOTS | Per-slot writeback enable, two edges after issue |
| wb_spill | output | SLOTS*2 | Per-slot pair {true, false} read for the slot's destination |

## Verification
The assertions assume that no restore ever supplies the pair with both bits set. Only under that assumption does the legal-pair property hold. The random stimulus draws restore data from the three legal pairs only, and draws guard and destination indices across the whole file, index 0 included. It mixes op codes, relations, signedness and operands that are often small and equal, so that the equality and sign-boundary cases come up often. Directed bundles cover same-bundle forwarding, squashed nested compares, writes to the null predicate and two slots writing one predicate.

// File: rtl/cpred_pkg.sv
package cpred_pkg;

    typedef enum logic [2:0] {
        OP_PLAIN   = 3'd0,
        OP_CLEAR   = 3'd1,
        OP_CMP     = 3'd2,
        OP_RESTORE = 3'd3,
        OP_SPILL   = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_NE = 2'd1,
        REL_GT = 2'd2,
        REL_LT = 2'd3
    } rel_e;

    // complementary predicate pair, true sense in the upper bit
    typedef struct packed {
        logic t;
        logic f;
    } pair_t;

    localparam pair_t PAIR_NULL = '{t: 1'b1, f: 1'b0};
    localparam pair_t PAIR_NONE = '{t: 1'b0, f: 1'b0};

    function automatic logic pick_sense(pair_t p, logic neg);
        return neg ? p.f : p.t;
    endfunction

endpackage

// File: rtl/cpred_cmp.sv
module cpred_cmp
    import cpred_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        rel,
    input  logic              uns,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              res
);
    logic gt_s, lt_s, gt_u, lt_u;

    always_comb begin
        gt_s = $signed(a) > $signed(b);
        lt_s = $signed(a) < $signed(b);
        gt_u = a > b;
        lt_u = a < b;
        case (rel_e'(rel))
            REL_EQ:  res = (a == b);
            REL_NE:  res = (a != b);
            REL_GT:  res = uns ? gt_u : gt_s;
            default: res = uns ? lt_u : lt_s;
        endcase
    end
endmodule

// File: rtl/cpred_slot.sv
module cpred_slot
    import cpred_pkg::*;
#(
    parameter int NP = 16,
    parameter int IW = $clog2(NP)
) (
    input  pair_t [NP-1:0] view_in,
    input  logic           vld,
    input  logic [2:0]     op,
    input  logic [IW-1:0]  dst,
    input  logic [IW-1:0]  gidx,
    input  logic           gneg,
    input  logic           res,
    input  pair_t          rd,
    output pair_t [NP-1:0] view_out,
    output logic           go,
    output pair_t          spill
);
    pair_t gpair;

    always_comb begin
        gpair = (gidx == '0) ? PAIR_NULL : view_in[gidx];
        go    = vld & pick_sense(gpair, gneg);
        spill = (dst == '0) ? PAIR_NULL : view_in[dst];

        view_out = view_in;
        if (go && dst != '0) begin
            case (op_e'(op))
                OP_CLEAR:   view_out[dst] = PAIR_NONE;
                OP_CMP:     view_out[dst] = '{t: res, f: ~res};
                OP_RESTORE: view_out[dst] = rd;
                default:    view_out[dst] = view_in[dst];
            endcase
        end
    end
endmodule

// File: rtl/cpred_file.sv
module cpred_file
    import cpred_pkg::*;
#(
    parameter int NP     = 16,
    parameter int SLOTS  = 2,
    parameter int DATA_W = 32,
    parameter int IW     = $clog2(NP)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SLOTS-1:0]              iss_valid,
    input  logic [SLOTS-1:0][2:0]         iss_op,
    input  logic [SLOTS-1:0][1:0]         iss_rel,
    input  logic [SLOTS-1:0]              iss_unsigned,
    input  logic [SLOTS-1:0][DATA_W-1:0]  iss_opa,
    input  logic [SLOTS-1:0][DATA_W-1:0]  iss_opb,
    input  logic [SLOTS-1:0][IW-1:0]      iss_dst,
    input  logic [SLOTS-1:0][IW-1:0]      iss_gidx,
    input  logic [SLOTS-1:0]              iss_gneg,
    input  logic [SLOTS-1:0][1:0]         iss_rdata,
    output logic [SLOTS-1:0]              wb_en,
    output logic [SLOTS-1:0][1:0]         wb_spill
);
    typedef struct packed {
        logic          vld;
        logic [2:0]    op;
        logic [IW-1:0] dst;
        logic [IW-1:0] gidx;
        logic          gneg;
        logic          res;
        pair_t         rd;
    } mem_t;

    pair_t [NP-1:0]    pfile;
    pair_t [NP-1:0]    view [SLOTS+1];
    mem_t  [SLOTS-1:0] mem_q;
    logic  [SLOTS-1:0] ex_res;
    logic  [SLOTS-1:0] go;
    pair_t [SLOTS-1:0] spill;

    assign view[0] = pfile;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        cpred_cmp #(.DATA_W(DATA_W)) u_cmp (
            .rel (iss_rel[s]),
            .uns (iss_unsigned[s]),
            .a   (iss_opa[s]),
            .b   (iss_opb[s]),
            .res (ex_res[s])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[s] <= '0;
            end else begin
                mem_q[s].vld  <= iss_valid[s];
                mem_q[s].op   <= iss_op[s];
                mem_q[s].dst  <= iss_dst[s];
                mem_q[s].gidx <= iss_gidx[s];
                mem_q[s].gneg <= iss_gneg[s];
                mem_q[s].res  <= ex_res[s];
                mem_q[s].rd   <= iss_rdata[s];
            end
        end

        cpred_slot #(.NP(NP), .IW(IW)) u_slot (
            .view_in  (view[s]),
            .vld      (mem_q[s].vld),
            .op       (mem_q[s].op),
            .dst      (mem_q[s].dst),
            .gidx     (mem_q[s].gidx),
            .gneg     (mem_q[s].gneg),
            .res      (mem_q[s].res),
            .rd       (mem_q[s].rd),
            .view_out (view[s+1]),
            .go       (go[s]),
            .spill    (spill[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pfile    <= '0;
            wb_en    <= '0;
            wb_spill <= '0;
        end else begin
            pfile    <= view[SLOTS];
            wb_en    <= go;
            wb_spill <= spill;
        end
    end
endmodule

// File: rtl/cpred_file_chk.sv
module cpred_file_chk #(
    parameter int NP    = 16,
    parameter int SLOTS = 2,
    parameter int IW    = $clog2(NP)
) (
    input logic                     clk,
    input logic                     rst,
    input logic [SLOTS-1:0]         iss_valid,
    input logic [SLOTS-1:0][2:0]    iss_op,
    input logic [SLOTS-1:0][IW-1:0] iss_dst,
    input logic [SLOTS-1:0][IW-1:0] iss_gidx,
    input logic [SLOTS-1:0]         iss_gneg,
    input logic [SLOTS-1:0]         wb_en,
    input logic [SLOTS-1:0][1:0]    wb_spill,
    input logic [NP-1:0][1:0]       pfile
);
    for (genvar i = 0; i < NP; i++) begin : g_pair
        // R2: no stored pair has both senses set
        a_r2_pair_legal: assert property (@(posedge clk) disable iff (rst)
            pfile[i] != 2'b11);
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_s
        // R6: an empty issue slot never produces a writeback
        a_r6_idle_no_wb: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst, 1) && !$past(rst, 2) && !$past(iss_valid[s], 2))
            |-> !wb_en[s]);

        // R10: guard on the null predicate's true sense always passes
        a_r10_null_true: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst, 1) && !$past(rst, 2) &&
             $past(iss_valid[s] && iss_gidx[s] == '0 && !iss_gneg[s], 2))
            |-> wb_en[s]);

        // R10: guard on the null predicate's false sense never passes
        a_r10_null_false: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst, 1) && !$past(rst, 2) &&
             $past(iss_gidx[s] == '0 && iss_gneg[s], 2))
            |-> !wb_en[s]);

        // R9: spill of the null predicate returns true/false
        a_r9_spill_null: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst, 1) && !$past(rst, 2) &&
             $past(iss_op[s] == 3'd4 && iss_dst[s] == '0, 2))
            |-> wb_spill[s] == 2'b10);
    end
endmodule

bind cpred_file cpred_file_chk #(.NP(NP), .SLOTS(SLOTS), .IW(IW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_op    (iss_op),
    .iss_dst   (iss_dst),
    .iss_gidx  (iss_gidx),
    .iss_gneg  (iss_gneg),
    .wb_en     (wb_en),
    .wb_spill  (wb_spill),
    .pfile     (pfile)
);

// File: tb/cpred_file_tb_top.sv
module cpred_file_tb_top;
    localparam int SL = 2;
    localparam int NPB = 16;
    localparam int IWB = 4;
    localparam int WB = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [SL-1:0]          iss_valid = '0;
    logic [SL-1:0][2:0]     iss_op = '0;
    logic [SL-1:0][1:0]     iss_rel = '0;
    logic [SL-1:0]          iss_unsigned = '0;
    logic [SL-1:0][WB-1:0]  iss_opa = '0;
    logic [SL-1:0][WB-1:0]  iss_opb = '0;
    logic [SL-1:0][IWB-1:0] iss_dst = '0;
    logic [SL-1:0][IWB-1:0] iss_gidx = '0;
    logic [SL-1:0]          iss_gneg = '0;
    logic [SL-1:0][1:0]     iss_rdata = '0;
    logic [SL-1:0]          wb_en;
    logic [SL-1:0][1:0]     wb_spill;

    always #2.5 clk = ~clk;

    cpred_file #(.NP(NPB), .SLOTS(SL), .DATA_W(WB)) dut_i (.*);

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    // bench model of the predicate file
    logic m_t [NPB];
    logic m_f [NPB];

    // bundle being prepared
    logic [SL-1:0]          b_valid;
    logic [SL-1:0][2:0]     b_op;
    logic [SL-1:0][1:0]     b_rel;
    logic [SL-1:0]          b_uns;
    logic [SL-1:0][WB-1:0]  b_a, b_b;
    logic [SL-1:0][IWB-1:0] b_dst, b_gidx;
    logic [SL-1:0]          b_gneg;
    logic [SL-1:0][1:0]     b_rd;
    string                  b_tag [SL];

    // expectation pipeline, index 2 is due for checking
    logic  e_en [3][SL];
    logic  [1:0] e_sp [3][SL];
    logic  e_isspill [3][SL];
    string e_tag [3][SL];

    function automatic logic rel_model(logic [1:0] rel, logic uns,
                                       logic [WB-1:0] a, logic [WB-1:0] b);
        logic [WB-1:0] ka, kb;
        ka = uns ? a : (a ^ {1'b1, {(WB-1){1'b0}}});
        kb = uns ? b : (b ^ {1'b1, {(WB-1){1'b0}}});
        case (rel)
            2'd0: return ka == kb;
            2'd1: return ka != kb;
            2'd2: return ka > kb;
            default: return ka < kb;
        endcase
    endfunction

    function automatic string auto_tag(int s);
        if (b_tag[s] != "") return b_tag[s];
        if (b_gidx[s] == 0) return "R10";
        case (b_op[s])
            3'd1: return "R3";
            3'd2: return b_uns[s] ? "R5" : "R4";
            3'd3, 3'd4: return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clr_bundle();
        b_valid = '0; b_op = '0; b_rel = '0; b_uns = '0; b_a = '0; b_b = '0;
        b_dst = '0; b_gidx = '0; b_gneg = '0; b_rd = '0;
        for (int s = 0; s < SL; s++) b_tag[s] = "";
    endtask

    task automatic set_slot(int s, logic [2:0] op, logic [1:0] rel, logic uns,
                            logic [WB-1:0] a, logic [WB-1:0] b, int dst,
                            int gidx, logic gneg, logic [1:0] rd, string tag);
        b_valid[s] = 1'b1; b_op[s] = op; b_rel[s] = rel; b_uns[s] = uns;
        b_a[s] = a; b_b[s] = b; b_dst[s] = IWB'(dst); b_gidx[s] = IWB'(gidx);
        b_gneg[s] = gneg; b_rd[s] = rd; b_tag[s] = tag;
    endtask

    task automatic step();
        logic gt, gf, go, r;
        @(negedge clk);
        e_en[2] = e_en[1]; e_sp[2] = e_sp[1]; e_isspill[2] = e_isspill[1]; e_tag[2] = e_tag[1];
        e_en[1] = e_en[0]; e_sp[1] = e_sp[0]; e_isspill[1] = e_isspill[0]; e_tag[1] = e_tag[0];
        for (int s = 0; s < SL; s++) begin
            check({e_tag[2][s], " wb_en"}, {1'b0, wb_en[s]}, {1'b0, e_en[2][s]});
            if (e_isspill[2][s] && e_en[2][s]) begin
                check({e_tag[2][s], " spill"}, wb_spill[s], e_sp[2][s]);
                check("R2 spill legal", {1'b0, wb_spill[s] == 2'b11}, 2'b00);
            end
        end
        iss_valid = b_valid; iss_op = b_op; iss_rel = b_rel; iss_unsigned = b_uns;
        iss_opa = b_a; iss_opb = b_b; iss_dst = b_dst; iss_gidx = b_gidx;
        iss_gneg = b_gneg; iss_rdata = b_rd;
        for (int s = 0; s < SL; s++) begin
            gt = (b_gidx[s] == 0) ? 1'b1 : m_t[b_gidx[s]];
            gf = (b_gidx[s] == 0) ? 1'b0 : m_f[b_gidx[s]];
            go = b_valid[s] && (b_gneg[s] ? gf : gt);
            e_en[0][s] = go;
            e_isspill[0][s] = (b_op[s] == 3'd4);
            e_sp[0][s] = (b_dst[s] == 0) ? 2'b10 : {m_t[b_dst[s]], m_f[b_dst[s]]};
            e_tag[0][s] = auto_tag(s);
            if (go && b_dst[s] != 0) begin
                case (b_op[s])
                    3'd1: begin m_t[b_dst[s]] = 1'b0; m_f[b_dst[s]] = 1'b0; end
                    3'd2: begin
                        r = rel_model(b_rel[s], b_uns[s], b_a[s], b_b[s]);
                        m_t[b_dst[s]] = r; m_f[b_dst[s]] = ~r;
                    end
                    3'd3: begin m_t[b_dst[s]] = b_rd[s][1]; m_f[b_dst[s]] = b_rd[s][0]; end
                    default: ;
                endcase
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NPB; i++) begin m_t[i] = 1'b0; m_f[i] = 1'b0; end
        for (int k = 0; k < 3; k++)
            for (int s = 0; s < SL; s++) begin
                e_en[k][s] = 1'b0; e_sp[k][s] = 2'b00; e_isspill[k][s] = 1'b0; e_tag[k][s] = "R6";
            end
        clr_bundle();
        repeat (3) @(negedge clk);
        check("R1 reset wb_en", {1'b0, wb_en[0] | wb_en[1]}, 2'b00);
        rst = 1'b0;

        // R1: fresh predicate squashes both senses
        clr_bundle(); set_slot(0, 0, 0, 0, 0, 0, 0, 5, 0, 0, "R1"); set_slot(1, 0, 0, 0, 0, 0, 0, 5, 1, 0, "R1"); step();
        // R8: compare and its user in one bundle
        clr_bundle(); set_slot(0, 2, 2, 0, 5, 3, 1, 0, 0, 0, "R4"); set_slot(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R8"); step();
        clr_bundle(); set_slot(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, "R6"); set_slot(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R6"); step();
        // R7: nested compare guarded by a false predicate does nothing
        clr_bundle(); set_slot(0, 2, 0, 0, 7, 7, 2, 1, 1, 0, "R7"); set_slot(1, 0, 0, 0, 0, 0, 0, 2, 0, 0, "R7"); step();
        clr_bundle(); set_slot(0, 0, 0, 0, 0, 0, 0, 2, 1, 0, "R7"); step();
        // R5: signed versus unsigned on -1 < 1
        clr_bundle(); set_slot(0, 2, 3, 0, '1, 1, 3, 0, 0, 0, "R5"); set_slot(1, 2, 3, 1, '1, 1, 4, 0, 0, 0, "R5"); step();
        clr_bundle(); set_slot(0, 0, 0, 0, 0, 0, 0, 3, 0, 0, "R5"); set_slot(1, 0, 0, 0, 0, 0, 0, 4, 1, 0, "R5"); step();
        // R3: clear then both senses squash
        clr_bundle(); set_slot(0, 1, 0, 0, 0, 0, 3, 0, 0, 0, "R3"); set_slot(1, 0, 0, 0, 0, 0, 0, 3, 1, 0, "R3"); step();
        clr_bundle(); set_slot(0, 0, 0, 0, 0, 0, 0, 3, 0, 0, "R3"); step();
        // R10: writes to the null predicate are ignored
        clr_bundle(); set_slot(0, 2, 0, 0, 1, 2, 0, 0, 0, 0, "R10"); set_slot(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10"); step();
        clr_bundle(); set_slot(0, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R10"); set_slot(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R10"); step();
        // R9: restore and spill, forwarded in bundle
        clr_bundle(); set_slot(0, 3, 0, 0, 0, 0, 6, 0, 0, 2'b01, "R9"); set_slot(1, 4, 0, 0, 0, 0, 6, 0, 0, 0, "R9"); step();
        clr_bundle(); set_slot(0, 4, 0, 0, 0, 0, 6, 0, 0, 0, "R9"); step();
        // R8: two writes to one predicate, higher slot kept
        clr_bundle(); set_slot(0, 3, 0, 0, 0, 0, 7, 0, 0, 2'b10, "R8"); set_slot(1, 3, 0, 0, 0, 0, 7, 0, 0, 2'b01, "R8"); step();
        clr_bundle(); set_slot(0, 0, 0, 0, 0, 0, 0, 7, 1, 0, "R8"); set_slot(1, 0, 0, 0, 0, 0, 0, 7, 0, 0, "R8"); step();

        for (int n = 0; n < 3000; n++) begin
            clr_bundle();
            for (int s = 0; s < SL; s++) begin
                logic [2:0] op;
                logic [1:0] rd;
                logic [WB-1:0] a, b;
                int pick;
                pick = int'($urandom % 10);
                op = (pick < 3) ? 3'd2 : (pick < 4) ? 3'd1 : (pick < 5) ? 3'd3 :
                     (pick < 6) ? 3'd4 : 3'($urandom % 8);
                if (op == 3'd1 || op == 3'd2 || op == 3'd3 || op == 3'd4) ; else op = (op > 4) ? op : 3'd0;
                case ($urandom % 3) 0: rd = 2'b00; 1: rd = 2'b10; default: rd = 2'b01; endcase
                a = ($urandom % 2) ? WB'($urandom % 4) : WB'($urandom);
                b = ($urandom % 2) ? WB'($urandom % 4) : WB'($urandom);
                set_slot(s, op, 2'($urandom), 1'($urandom), a, b, int'($urandom % NPB),
                         int'($urandom % NPB), 1'($urandom), rd, "");
                b_valid[s] = ($urandom % 8) != 0;
            end
            step();
        end
        clr_bundle();
        repeat (3) step();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule